// File: doc/BRIEF.md
# Banked Register Window with Masked Interrupt

This block is the host-side register front end of a network controller. It offers a small window of word offsets, and the meaning of most offsets depends on which of four banks is selected. The bank number is held in a selector register at the top offset of the window. That offset is decoded the same way in every bank, so host software can always find it and switch banks. The upper byte of the selector always reads back a fixed identification value, which software can use to check that the device is present.

Bank 2 gathers the interrupt sources from the datapath into a status register and holds an enable mask. Writing a one to a bit at the status offset clears that bit. A single registered interrupt line is raised whenever any status bit is both set and enabled. Bank 3 exposes a read-only revision word that carries a chip code and a revision number. The MAC and the packet memory sit outside this block; only their event lines come in.

Top module: `bank_regwin`

## Requirements
- R1: After a synchronous active-low reset the bank number is 0, the mask is 0, the status is 0 and `irq` is 0.
- R2: The selector (offset 7) reads `{ID_VAL[7:0], 6'b0, bank[1:0]}`. Only bits [1:0] are writable. The identification byte (default 8'h33) never changes, including after any write.
- R3: The selector is read and written at offset 7 whatever bank is selected.
- R4: In bank 3, offset 2 reads `{8'h00, CHIP[3:0], REV[3:0]}` (default 16'h0092).
- R5: In bank 2, offset 0 reads the status in bits [5:0]. A one on `evt_pulse[k]` sets status bit k+1 on the next clock edge, and the bit stays set until it is acknowledged. The bit assignments are: 1 transmit error, 2 allocation done, 3 receive overrun, 4 transmit empty, 5 PHY event.
- R6: A host write at bank 2 offset 0 clears exactly the status bits written as one and leaves the others unchanged.
- R7: When an event and its acknowledge arrive in the same cycle, the event wins and the status bit stays set.
- R8: The mask (bank 2, offset 1, bits [5:0]) gates only the interrupt line. A zero mask holds `irq` low and keeps every pending status bit.
- R9: `irq` is the OR of (status AND mask), registered. It changes on the clock edge after the status or mask change.
- R10: Status bit 0 (receive) is set in every cycle in which `rxq_nonempty` is high, so acknowledging it has no effect while the queue is not empty.
- R11: Offsets that are not mapped in the current bank read 0. This includes the status and mask offsets when bank 2 is not selected.
- R12: Writes to the revision offset and to unmapped offsets change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W (3) | Word offset within the window |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | DATA_W (16) | Write data |
| host_rdata | output | DATA_W (16) | Read data for `host_addr`, combinational |
| rxq_nonempty | input | 1 | Level: the receive queue holds packets |
| evt_pulse | input | NSRC-1 (5) | One-cycle event pulses for status bits 1..5 |
| irq | output | 1 | Registered interrupt request |

## Verification
A table of cases drives different combinations of event pulses under different masks. It compares the status word and `irq`, which shows that the mask gates only the interrupt line and never the status. Some cases enable exactly the pending source, others enable only an idle one or none at all; these tell a correct AND-then-OR apart from a plain OR of the status or a wrong bit order. Directed cases cover the following:
- partial and colliding acknowledges;
- the one-cycle latency of `irq` after a mask change;
- the level-driven receive bit;
- reads of the identification byte, revision word and unmapped offsets across banks.

// File: rtl/regwin_pkg.sv
// Package: shared offsets, bank numbers and widths of the banked window.
// Assumes word offsets of at least 3 bits.
package regwin_pkg;
    localparam int BANK_W   = 2;
    localparam int OFF_STAT = 0;   // bank 2: status read, W1C acknowledge write
    localparam int OFF_MASK = 1;   // bank 2: interrupt enable mask
    localparam int OFF_REV  = 2;   // bank 3: revision word
    localparam int OFF_BANK = 7;   // every bank: selector
    localparam int BANK_IRQ = 2;
    localparam int BANK_REV = 3;
    typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/regwin_bank.sv
// Module: bank number register of the window.
// Assumes the write strobe is already decoded for the selector offset.
module regwin_bank
    import regwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_we,
    input  bank_t sel_wdata,
    output bank_t bank_q
);
    // Hold the bank number; only the low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (sel_we)
            bank_q <= sel_wdata;
    end
endmodule

// File: rtl/regwin_irq.sv
// Module: interrupt status, mask and registered interrupt line.
// Status bit 0 follows a level input; the other bits are set by one-cycle
// pulses. A set on the same edge as an acknowledge wins.
module regwin_irq #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_we,
    input  logic            mask_we,
    input  logic [NSRC-1:0] wbits,
    input  logic            rx_level,
    input  logic [NSRC-2:0] pulses,
    output logic [NSRC-1:0] stat_q,
    output logic [NSRC-1:0] mask_q,
    output logic            irq_q
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    // Collect this cycle's set and clear requests.
    always_comb begin
        set_vec = {pulses, rx_level};
        clr_vec = ack_we ? wbits : '0;
    end

    // Sticky status with write-one-to-clear; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= wbits;
    end

    // Registered request from the enabled pending sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat_q & mask_q);
    end
endmodule

// File: rtl/regwin_rdmux.sv
// Module: read data selection of the banked window.
// Unmapped offsets read zero; the selector is decoded in every bank.
module regwin_rdmux
    import regwin_pkg::*;
#(
    parameter int              ADDR_W = 3,
    parameter int              DATA_W = 16,
    parameter int              NSRC   = 6,
    parameter int              ID_W   = 8,
    parameter int              CODE_W = 4,
    parameter logic [ID_W-1:0]   ID_VAL = 8'h33,
    parameter logic [CODE_W-1:0] CHIP   = 4'h9,
    parameter logic [CODE_W-1:0] REV    = 4'h2
) (
    input  logic [ADDR_W-1:0] addr,
    input  bank_t             bank_q,
    input  logic [NSRC-1:0]   stat_q,
    input  logic [NSRC-1:0]   mask_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int SEL_PAD = DATA_W - ID_W - BANK_W;
    localparam int SRC_PAD = DATA_W - NSRC;
    localparam int REV_PAD = DATA_W - 2*CODE_W;

    // Decode offset and bank into one read word.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_BANK))
            rdata = {ID_VAL, {SEL_PAD{1'b0}}, bank_q};
        else if (bank_q == bank_t'(BANK_IRQ) && addr == ADDR_W'(OFF_STAT))
            rdata = {{SRC_PAD{1'b0}}, stat_q};
        else if (bank_q == bank_t'(BANK_IRQ) && addr == ADDR_W'(OFF_MASK))
            rdata = {{SRC_PAD{1'b0}}, mask_q};
        else if (bank_q == bank_t'(BANK_REV) && addr == ADDR_W'(OFF_REV))
            rdata = {{REV_PAD{1'b0}}, CHIP, REV};
    end
endmodule

// File: rtl/bank_regwin.sv
// Module: banked register window with interrupt status, mask and line.
// Assumes one host access per cycle; reads are combinational.
module bank_regwin
    import regwin_pkg::*;
#(
    parameter int              ADDR_W = 3,
    parameter int              DATA_W = 16,
    parameter int              NSRC   = 6,
    parameter int              ID_W   = DATA_W / 2,
    parameter int              CODE_W = 4,
    parameter logic [ID_W-1:0]   ID_VAL = 8'h33,
    parameter logic [CODE_W-1:0] CHIP   = 4'h9,
    parameter logic [CODE_W-1:0] REV    = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rxq_nonempty,
    input  logic [NSRC-2:0]   evt_pulse,
    output logic              irq
);
    bank_t           bank_q;
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] mask_q;
    logic            sel_we, ack_we, mask_we, in_irq_bank;
    logic            unused_wdata;

    assign unused_wdata = ^host_wdata[DATA_W-1:NSRC];

    // Decode write strobes per offset and bank.
    always_comb begin
        in_irq_bank = (bank_q == bank_t'(BANK_IRQ));
        sel_we      = host_we && host_addr == ADDR_W'(OFF_BANK);
        ack_we      = host_we && in_irq_bank && host_addr == ADDR_W'(OFF_STAT);
        mask_we     = host_we && in_irq_bank && host_addr == ADDR_W'(OFF_MASK);
    end

    regwin_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (host_wdata[BANK_W-1:0]),
        .bank_q    (bank_q)
    );

    regwin_irq #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_we   (ack_we),
        .mask_we  (mask_we),
        .wbits    (host_wdata[NSRC-1:0]),
        .rx_level (rxq_nonempty),
        .pulses   (evt_pulse),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq_q    (irq)
    );

    regwin_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .ID_W(ID_W),
        .CODE_W(CODE_W), .ID_VAL(ID_VAL), .CHIP(CHIP), .REV(REV)
    ) u_rdmux (
        .addr   (host_addr),
        .bank_q (bank_q),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .rdata  (host_rdata)
    );
endmodule

// File: rtl/bank_regwin_chk.sv
// Module: property checker bound to the banked register window.
module bank_regwin_chk #(
    parameter int              ADDR_W = 3,
    parameter int              DATA_W = 16,
    parameter int              NSRC   = 6,
    parameter int              ID_W   = 8,
    parameter logic [ID_W-1:0] ID_VAL = 8'h33
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              rxq_nonempty,
    input logic [NSRC-2:0]   evt_pulse,
    input logic [NSRC-1:0]   stat_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq
);
    AST_SEL_ID: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(7) |-> host_rdata[DATA_W-1:DATA_W-ID_W] == ID_VAL); // R2
    AST_EVT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse != '0 |=> (stat_q[NSRC-1:1] & $past(evt_pulse)) == $past(evt_pulse)); // R7
    AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_nonempty |=> stat_q[0]); // R10
    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |=> !irq); // R8
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q)) |=> irq); // R9
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & mask_q)) |=> !irq); // R9
endmodule

bind bank_regwin bank_regwin_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .ID_W(ID_W), .ID_VAL(ID_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_rdata   (host_rdata),
    .rxq_nonempty (rxq_nonempty),
    .evt_pulse    (evt_pulse),
    .stat_q       (stat_q),
    .mask_q       (mask_q),
    .irq          (irq)
);

// File: tb/bank_regwin_tb.sv
module bank_regwin_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rxq_nonempty = 1'b0;
    logic [4:0]  evt_pulse = '0;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    // vector: {mask[5:0], pulses[4:0], expected status[5:0], expected irq}
    localparam logic [17:0] VEC [6] = '{
        {6'h3F, 5'b00001, 6'h02, 1'b1},
        {6'h00, 5'b11111, 6'h3E, 1'b0},
        {6'h04, 5'b00010, 6'h04, 1'b1},
        {6'h04, 5'b00100, 6'h08, 1'b0},
        {6'h30, 5'b10000, 6'h20, 1'b1},
        {6'h01, 5'b01010, 6'h14, 1'b0}
    };

    always #10 clk = ~clk;

    bank_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rxq_nonempty(rxq_nonempty), .evt_pulse(evt_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_we = 1'b1; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        host_addr = a;
        #2 d = host_rdata;
    endtask

    task automatic pulse(input logic [4:0] p);
        @(negedge clk);
        evt_pulse = p;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and R2 identification byte
        rd(3'd7, r); check("R1 bank after reset", r, 16'h3300);
        check("R1 irq after reset", {15'd0, irq}, 16'h0000);
        wr(3'd7, 16'd2);
        rd(3'd1, r); check("R1 mask after reset", r, 16'h0000);
        rd(3'd0, r); check("R1 status after reset", r, 16'h0000);

        // table walk: R5 sticky set, R8 mask gating, R9 OR of status and mask
        foreach (VEC[i]) begin
            wr(3'd0, 16'h003F);
            wr(3'd1, {10'd0, VEC[i][17:12]});
            pulse(VEC[i][11:7]);
            @(negedge clk);
            rd(3'd0, r); check("R5 status vector", r, {10'd0, VEC[i][6:1]});
            check("R9 irq vector", {15'd0, irq}, {15'd0, VEC[i][0]});
        end

        // R6 partial acknowledge
        wr(3'd0, 16'h003F);
        pulse(5'b00011);
        wr(3'd0, 16'h0002);
        rd(3'd0, r); check("R6 partial ack", r, 16'h0004);

        // R7 event and acknowledge in the same cycle
        @(negedge clk);
        host_addr = 3'd0; host_we = 1'b1; host_wdata = 16'h0006; evt_pulse = 5'b00001;
        @(negedge clk);
        host_we = 1'b0; evt_pulse = '0;
        rd(3'd0, r); check("R7 set beats ack", r, 16'h0002);

        // R8 zero mask keeps status; R9 one-cycle latency after unmask
        wr(3'd1, 16'h0000);
        @(negedge clk);
        check("R8 irq masked", {15'd0, irq}, 16'h0000);
        rd(3'd0, r); check("R8 status kept", r, 16'h0002);
        @(negedge clk);
        host_addr = 3'd1; host_we = 1'b1; host_wdata = 16'h003F;
        @(negedge clk);
        host_we = 1'b0;
        check("R9 irq not yet", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        check("R9 irq after one cycle", {15'd0, irq}, 16'h0001);

        // R10 level-driven receive bit
        wr(3'd0, 16'h003F);
        rxq_nonempty = 1'b1;
        @(negedge clk);
        wr(3'd0, 16'h0001);
        rd(3'd0, r); check("R10 rx ack ignored", r, 16'h0001);
        rxq_nonempty = 1'b0;
        wr(3'd0, 16'h0001);
        rd(3'd0, r); check("R10 rx cleared when empty", r, 16'h0000);

        // R2 only bank bits writable; R3 selector in every bank; R4 revision
        pulse(5'b00001);
        wr(3'd7, 16'hFFFF);
        rd(3'd7, r); check("R2 selector after all-ones", r, 16'h3303);
        rd(3'd2, r); check("R4 revision word", r, 16'h0092);
        wr(3'd2, 16'hFFFF);
        rd(3'd2, r); check("R12 revision unchanged", r, 16'h0092);
        rd(3'd5, r); check("R11 unmapped in bank 3", r, 16'h0000);
        wr(3'd7, 16'h0000);
        rd(3'd7, r); check("R3 selector from bank 0", r, 16'h3300);
        rd(3'd0, r); check("R11 status hidden in bank 0", r, 16'h0000);
        wr(3'd5, 16'hFFFF);
        wr(3'd7, 16'h0002);
        rd(3'd0, r); check("R12 status after unmapped write", r, 16'h0002);
        rd(3'd1, r); check("R12 mask after unmapped write", r, 16'h003F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule